// File: doc/BRIEF.md
# AUX Request Framing and Retry Sequencer

This block sits between a request source and an auxiliary-channel line controller. A request carries a 4-bit request code, a 20-bit target address, a payload length and up to sixteen payload bytes. The sequencer classifies the request as a write or a read, builds the header and the transmit frame, and works out how many reply bytes to expect. It then waits for the line controller to go idle and launches the frame. Failed attempts are retried: a timed-out attempt is relaunched at once, and a receive error is first followed by a backoff wait.

When an attempt completes cleanly, the sequencer decodes the reply. The reply code is the upper nibble of the first reply byte. A read hands back the remaining bytes as payload. A write reports how many bytes the target accepted. Each accepted request ends with exactly one result pulse, which carries a status code, the reply code, a byte count and any read payload. Requests with an unknown code, or too large to fit a 20-byte message, are rejected without the controller ever being started.

Top module: `aux_seq`

## Requirements
- R1: Transmit byte k sits at ctl_tx_data_o[8k+7:8k]. Byte 0 holds the 4-bit request code in bits 7:4 and address bits 19:16 in bits 3:0. Byte 1 holds address bits 15:8 and byte 2 holds address bits 7:0. When the length is non-zero, byte 3 is the length minus one, and for writes the payload follows from byte 4 (payload byte j taken from req_data_i[8j+7:8j]).
- R2: A zero-length request is sent as a 3-byte address-only frame with no length byte, for writes and reads alike.
- R3: A write with a non-zero length sends 4 plus the length bytes. A write longer than 16 bytes ends with result code 5 (too big), and the controller is never started.
- R4: A non-zero-length read sends 4 bytes and expects length plus 1 reply bytes. A read longer than 19 bytes ends with result code 5, and the controller is never started.
- R5: The request code is classified with bit 2 (continuation flag) cleared. 1000 is a native write and 1001 a native read. 0000 is a bus write, 0001 a bus read, and 0010 a bus write with status update. Any other code ends with result code 4 (invalid), and the controller is never started. Result codes: 0 ok, 1 busy, 2 I/O error, 3 timeout, 4 invalid, 5 too big.
- R6: Before the first attempt, the controller busy flag is sampled up to 3 times, POLL_GAP_CYC cycles apart. If all 3 samples are busy, the result is code 1 and no attempt is made.
- R7: At most 5 attempts are made per request. After a timeout completion, the next start is issued in the completion's following cycle. After a receive-error completion (without a timeout), the next start comes no sooner than BACKOFF_CYC cycles later. A timeout takes precedence over a receive error when choosing how to retry.
- R8: If all 5 attempts fail, the result is code 2 when the last completion flagged a receive error, and otherwise code 3.
- R9: A clean completion that reports a reply size of 0 or more than 20 ends with result code 1.
- R10: For a read, the reply code is reply byte 0 bits 7:4. The count is min(reply size, length+1) minus 1, and reply byte k+1 appears at res_data_o[8k+7:8k], with unused bytes zero.
- R11: For a write, if the reply size is at least 2, the count is reply byte 1 clamped to the requested length. Otherwise the count is the requested length.
- R12: req_ready_o is high only while idle. Each accepted request produces exactly one single-cycle res_valid_o pulse. A rejected request's result appears one cycle after acceptance, and a decoded result appears one cycle after the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_cmd_i | input | 4 | Request code |
| req_addr_i | input | 20 | Target address |
| req_len_i | input | 5 | Payload length in bytes |
| req_data_i | input | 128 | Write payload, byte j at bits 8j+7:8j |
| ctl_busy_i | input | 1 | Line controller busy |
| ctl_start_o | output | 1 | One-cycle launch of an attempt |
| ctl_tx_len_o | output | 5 | Transmit byte count |
| ctl_tx_data_o | output | 160 | Transmit frame |
| ctl_done_i | input | 1 | Attempt completion strobe |
| ctl_timeout_i | input | 1 | Completion flagged a timeout |
| ctl_rx_err_i | input | 1 | Completion flagged a receive error |
| ctl_rx_len_i | input | 5 | Reply byte count reported |
| ctl_rx_data_i | input | 160 | Reply bytes, byte 0 lowest |
| res_valid_o | output | 1 | Result pulse |
| res_code_o | output | 3 | Result status code |
| res_reply_o | output | 4 | Reply code |
| res_count_o | output | 5 | Byte count |
| res_data_o | output | 152 | Read payload |

## Verification
A rejected request reports one cycle after acceptance, so the bench samples on the falling edge immediately after the one following acceptance. A clean completion is decoded in the next cycle, and a fifth failed attempt reports in the completion cycle itself; the bench measures both distances in whole cycles from the falling edge where it releases the completion strobe. The spacing between attempts is taken from a free-running cycle count. A timeout retry must start within one cycle, and a receive-error retry must start between BACKOFF_CYC and BACKOFF_CYC+3 cycles later. The busy-poll result must take at least two poll gaps.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_BUSY    = 3'd1,
    RES_IO      = 3'd2,
    RES_TIMEOUT = 3'd3,
    RES_INVALID = 3'd4,
    RES_TOOBIG  = 3'd5
  } res_code_e;

  typedef enum logic [1:0] {KIND_BAD, KIND_WR, KIND_RD} req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_POLL, S_GAP, S_SEND, S_WAIT, S_BACKOFF, S_DECODE
  } seq_state_e;

  // continuation flag is bit 2 of the request code
  localparam logic [3:0] CONT_STRIP = 4'b1011;
  localparam logic [3:0] CODE_NAT_WR = 4'b1000;
  localparam logic [3:0] CODE_NAT_RD = 4'b1001;
  localparam logic [3:0] CODE_BUS_WR = 4'b0000;
  localparam logic [3:0] CODE_BUS_RD = 4'b0001;
  localparam logic [3:0] CODE_BUS_WS = 4'b0010;
endpackage

// File: rtl/aux_seq_timer.sv
module aux_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/aux_seq_frame.sv
module aux_seq_frame
  import aux_seq_pkg::*;
#(
  parameter int unsigned MSG_BYTES = 20,
  parameter int unsigned LEN_W     = 5
) (
  input  logic [3:0]               cmd_i,
  input  logic [19:0]              addr_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [(MSG_BYTES-4)*8-1:0] pay_i,
  output req_kind_e                kind_o,
  output logic                     too_big_o,
  output logic [LEN_W-1:0]         tx_len_o,
  output logic [MSG_BYTES*8-1:0]   tx_data_o,
  output logic [LEN_W-1:0]         rx_exp_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned PAY_BYTES = MSG_BYTES - 4;

  always_comb begin
    unique case (cmd_i & CONT_STRIP)
      CODE_NAT_WR, CODE_BUS_WR, CODE_BUS_WS: kind_o = KIND_WR;
      CODE_NAT_RD, CODE_BUS_RD:              kind_o = KIND_RD;
      default:                               kind_o = KIND_BAD;
    endcase
  end

  always_comb begin
    tx_data_o        = '0;
    tx_data_o[7:0]   = {cmd_i, addr_i[19:16]};
    tx_data_o[15:8]  = addr_i[15:8];
    tx_data_o[23:16] = addr_i[7:0];
    if (len_i != '0) tx_data_o[31:24] = 8'(len_i) - 8'd1;
    if (kind_o == KIND_WR) begin
      for (int k = 0; k < int'(PAY_BYTES); k++)
        if (k < int'(len_i)) tx_data_o[32+8*k +: 8] = pay_i[8*k +: 8];
    end
  end

  always_comb begin
    if (len_i == '0)            tx_len_o = LEN_W'(3);
    else if (kind_o == KIND_WR) tx_len_o = LEN_W'(4) + len_i;
    else                        tx_len_o = LEN_W'(4);
    rx_exp_o  = (kind_o == KIND_WR) ? LEN_W'(2) : len_i + LEN_W'(1);
    too_big_o = (kind_o == KIND_WR) ? (int'(len_i) > int'(PAY_BYTES))
                                    : (int'(len_i) > int'(MSG_BYTES) - 1);
  end
endmodule

// File: rtl/aux_seq_reply.sv
module aux_seq_reply #(
  parameter int unsigned MSG_BYTES = 20,
  parameter int unsigned LEN_W     = 5
) (
  input  logic                       is_rd_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [LEN_W-1:0]           rx_exp_i,
  input  logic [LEN_W-1:0]           rx_len_i,
  input  logic [MSG_BYTES*8-1:0]     rx_data_i,
  output logic                       bad_size_o,
  output logic [3:0]                 reply_o,
  output logic [LEN_W-1:0]           count_o,
  output logic [(MSG_BYTES-1)*8-1:0] pay_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [LEN_W-1:0] eff;
  logic [7:0]       short_cnt;
  logic             unused_lo_nibble;

  assign unused_lo_nibble = ^rx_data_i[3:0];
  assign eff        = (rx_len_i < rx_exp_i) ? rx_len_i : rx_exp_i;
  assign bad_size_o = (rx_len_i == '0) || (int'(rx_len_i) > int'(MSG_BYTES));
  assign reply_o    = rx_data_i[7:4];
  assign short_cnt  = rx_data_i[15:8];

  always_comb begin
    if (is_rd_i)                  count_o = eff - LEN_W'(1);
    else if (eff >= LEN_W'(2))    count_o = (short_cnt < 8'(len_i)) ? LEN_W'(short_cnt) : len_i;
    else                          count_o = len_i;
  end

  always_comb begin
    pay_o = '0;
    for (int k = 0; k < int'(MSG_BYTES) - 1; k++)
      if (is_rd_i && (k < int'(count_o))) pay_o[8*k +: 8] = rx_data_i[8*(k+1) +: 8];
  end
endmodule

// File: rtl/aux_seq.sv
module aux_seq
  import aux_seq_pkg::*;
#(
  parameter int unsigned MSG_BYTES    = 20,
  parameter int unsigned MAX_ATTEMPTS = 5,
  parameter int unsigned POLL_TRIES   = 3,
  parameter int unsigned POLL_GAP_CYC = 200000,
  parameter int unsigned BACKOFF_CYC  = 80000
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_valid_i,
  output logic                               req_ready_o,
  input  logic [3:0]                         req_cmd_i,
  input  logic [19:0]                        req_addr_i,
  input  logic [$clog2(MSG_BYTES+1)-1:0]     req_len_i,
  input  logic [(MSG_BYTES-4)*8-1:0]         req_data_i,
  input  logic                               ctl_busy_i,
  output logic                               ctl_start_o,
  output logic [$clog2(MSG_BYTES+1)-1:0]     ctl_tx_len_o,
  output logic [MSG_BYTES*8-1:0]             ctl_tx_data_o,
  input  logic                               ctl_done_i,
  input  logic                               ctl_timeout_i,
  input  logic                               ctl_rx_err_i,
  input  logic [$clog2(MSG_BYTES+1)-1:0]     ctl_rx_len_i,
  input  logic [MSG_BYTES*8-1:0]             ctl_rx_data_i,
  output logic                               res_valid_o,
  output logic [2:0]                         res_code_o,
  output logic [3:0]                         res_reply_o,
  output logic [$clog2(MSG_BYTES+1)-1:0]     res_count_o,
  output logic [(MSG_BYTES-1)*8-1:0]         res_data_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned LEN_W   = $clog2(MSG_BYTES + 1);
  localparam int unsigned PAY_W   = (MSG_BYTES - 4) * 8;
  localparam int unsigned RPAY_W  = (MSG_BYTES - 1) * 8;
  localparam int unsigned ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int unsigned POLL_W  = $clog2(POLL_TRIES + 1);
  localparam int unsigned TMR_MAX = (POLL_GAP_CYC > BACKOFF_CYC) ? POLL_GAP_CYC : BACKOFF_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_e state_q, state_d;
  logic [POLL_W-1:0] poll_q;
  logic [ATT_W-1:0]  att_q;
  logic [3:0]        cmd_q;
  logic [19:0]       addr_q;
  logic [LEN_W-1:0]  len_q, rx_len_q;
  logic [PAY_W-1:0]  pay_q;
  logic [MSG_BYTES*8-1:0] rx_data_q;

  req_kind_e         kind;
  logic              too_big, bad_size, tmr_load, tmr_zero, fin;
  logic [LEN_W-1:0]  rx_exp, dec_count;
  logic [3:0]        dec_reply;
  logic [RPAY_W-1:0] dec_pay;
  logic [TMR_W-1:0]  tmr_val;
  res_code_e         fin_code;

  aux_seq_frame #(.MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)) u_frame (
    .cmd_i(cmd_q), .addr_i(addr_q), .len_i(len_q), .pay_i(pay_q),
    .kind_o(kind), .too_big_o(too_big), .tx_len_o(ctl_tx_len_o),
    .tx_data_o(ctl_tx_data_o), .rx_exp_o(rx_exp)
  );

  aux_seq_reply #(.MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)) u_reply (
    .is_rd_i(kind == KIND_RD), .len_i(len_q), .rx_exp_i(rx_exp),
    .rx_len_i(rx_len_q), .rx_data_i(rx_data_q), .bad_size_o(bad_size),
    .reply_o(dec_reply), .count_o(dec_count), .pay_o(dec_pay)
  );

  aux_seq_timer #(.W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = RES_OK;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE:  if (req_valid_i) state_d = S_CHECK;
      S_CHECK: begin
        if (kind == KIND_BAD) begin fin = 1'b1; fin_code = RES_INVALID; state_d = S_IDLE; end
        else if (too_big)     begin fin = 1'b1; fin_code = RES_TOOBIG;  state_d = S_IDLE; end
        else state_d = S_POLL;
      end
      S_POLL: begin
        if (!ctl_busy_i) state_d = S_SEND;
        else if (poll_q == POLL_W'(POLL_TRIES - 1)) begin
          fin = 1'b1; fin_code = RES_BUSY; state_d = S_IDLE;
        end else begin
          state_d = S_GAP; tmr_load = 1'b1; tmr_val = TMR_W'(POLL_GAP_CYC);
        end
      end
      S_GAP:  if (tmr_zero) state_d = S_POLL;
      S_SEND: state_d = S_WAIT;
      S_WAIT: begin
        if (ctl_done_i) begin
          if (ctl_timeout_i) begin
            if (att_q < ATT_W'(MAX_ATTEMPTS)) state_d = S_SEND;
            else begin
              fin = 1'b1; state_d = S_IDLE;
              fin_code = ctl_rx_err_i ? RES_IO : RES_TIMEOUT;
            end
          end else if (ctl_rx_err_i) begin
            if (att_q < ATT_W'(MAX_ATTEMPTS)) begin
              state_d = S_BACKOFF; tmr_load = 1'b1; tmr_val = TMR_W'(BACKOFF_CYC);
            end else begin
              fin = 1'b1; fin_code = RES_IO; state_d = S_IDLE;
            end
          end else state_d = S_DECODE;
        end
      end
      S_BACKOFF: if (tmr_zero) state_d = S_SEND;
      S_DECODE: begin
        fin = 1'b1; state_d = S_IDLE;
        fin_code = bad_size ? RES_BUSY : RES_OK;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      poll_q <= '0; att_q <= '0;
      cmd_q <= '0; addr_q <= '0; len_q <= '0; pay_q <= '0;
      rx_len_q <= '0; rx_data_q <= '0;
      res_valid_o <= 1'b0; res_code_o <= '0; res_reply_o <= '0;
      res_count_o <= '0; res_data_o <= '0;
    end else begin
      state_q     <= state_d;
      res_valid_o <= fin;
      if (state_q == S_IDLE) begin
        poll_q <= '0;
        att_q  <= '0;
        if (req_valid_i) begin
          cmd_q <= req_cmd_i; addr_q <= req_addr_i; len_q <= req_len_i; pay_q <= req_data_i;
        end
      end
      if (state_q == S_POLL && ctl_busy_i) poll_q <= poll_q + POLL_W'(1);
      if (state_q == S_SEND) att_q <= att_q + ATT_W'(1);
      if (state_q == S_WAIT && ctl_done_i) begin
        rx_len_q  <= ctl_rx_len_i;
        rx_data_q <= ctl_rx_data_i;
      end
      if (fin) begin
        res_code_o <= fin_code;
        if (state_q == S_DECODE && !bad_size) begin
          res_reply_o <= dec_reply;
          res_count_o <= dec_count;
          res_data_o  <= dec_pay;
        end else begin
          res_reply_o <= '0;
          res_count_o <= '0;
          res_data_o  <= '0;
        end
      end
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign ctl_start_o = (state_q == S_SEND);

  // checker state: attempts per request and spacing after a receive error
  logic [ATT_W:0] chk_starts_q;
  logic [31:0]    chk_since_q;
  logic           chk_rxerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_starts_q <= '0; chk_since_q <= '0; chk_rxerr_q <= 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        chk_starts_q <= '0; chk_rxerr_q <= 1'b0;
      end else if (ctl_start_o) chk_starts_q <= chk_starts_q + 1'b1;
      if (state_q == S_WAIT && ctl_done_i) begin
        chk_since_q <= '0;
        chk_rxerr_q <= ctl_rx_err_i && !ctl_timeout_i;
      end else if (chk_since_q != '1) chk_since_q <= chk_since_q + 32'd1;
    end
  end

  a_r7_attempt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_start_o |-> (chk_starts_q < (ATT_W+1)'(MAX_ATTEMPTS)));
  a_r7_backoff_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_start_o && chk_rxerr_q) |-> (chk_since_q >= BACKOFF_CYC));
  a_r7_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_start_o |=> !ctl_start_o);
  a_r3_tx_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_start_o |-> (ctl_tx_len_o >= LEN_W'(3) && int'(ctl_tx_len_o) <= int'(MSG_BYTES)));
  a_r12_res_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  a_r12_ready_at_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> req_ready_o);
  a_r12_no_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !ctl_start_o);
endmodule

// File: tb/aux_seq_tb_top.sv
module aux_seq_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int MSG = 20;
  localparam int G   = 30;
  localparam int B   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         req_valid = 1'b0, req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_data = '0;
  logic         ctl_busy = 1'b0, ctl_start;
  logic [4:0]   ctl_tx_len;
  logic [159:0] ctl_tx_data;
  logic         ctl_done = 1'b0, ctl_timeout = 1'b0, ctl_rx_err = 1'b0;
  logic [4:0]   ctl_rx_len = '0;
  logic [159:0] ctl_rx_data = '0;
  logic         res_valid;
  logic [2:0]   res_code;
  logic [3:0]   res_reply;
  logic [4:0]   res_count;
  logic [151:0] res_data;

  aux_seq #(.MSG_BYTES(MSG), .POLL_GAP_CYC(G), .BACKOFF_CYC(B)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_data_i(req_data),
    .ctl_busy_i(ctl_busy), .ctl_start_o(ctl_start), .ctl_tx_len_o(ctl_tx_len),
    .ctl_tx_data_o(ctl_tx_data), .ctl_done_i(ctl_done), .ctl_timeout_i(ctl_timeout),
    .ctl_rx_err_i(ctl_rx_err), .ctl_rx_len_i(ctl_rx_len), .ctl_rx_data_i(ctl_rx_data),
    .res_valid_o(res_valid), .res_code_o(res_code), .res_reply_o(res_reply),
    .res_count_o(res_count), .res_data_o(res_data)
  );

  int nchk = 0, nerr = 0, cyc = 0, n_starts = 0;
  int s_cyc, d_cyc;
  logic [4:0]   tx_len_q;
  logic [159:0] tx_q;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (ctl_start) n_starts++;

  task automatic check_eq(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] c, logic [19:0] a, int l, logic [127:0] d);
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = 5'(l); req_data = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output int n);
    n = 0;
    while (!res_valid && n < 3000) begin @(negedge clk); n++; end
    if (!res_valid) check_eq("R12", "result never arrived", 0, 1);
  endtask

  task automatic serve(bit to, bit re, int rl, logic [159:0] rd);
    int w = 0;
    while (!ctl_start && w < 3000) begin @(negedge clk); w++; end
    if (!ctl_start) check_eq("R7", "start never issued", 0, 1);
    s_cyc = cyc; tx_len_q = ctl_tx_len; tx_q = ctl_tx_data;
    @(negedge clk);
    ctl_done = 1'b1; ctl_timeout = to; ctl_rx_err = re;
    ctl_rx_len = 5'(rl); ctl_rx_data = rd;
    @(negedge clk);
    ctl_done = 1'b0; ctl_timeout = 1'b0; ctl_rx_err = 1'b0;
    d_cyc = cyc;
  endtask

  task automatic t_reset();
    check_eq("R12", "ready after reset", req_ready, 1);
    check_eq("R12", "res_valid after reset", res_valid, 0);
    check_eq("R7", "start after reset", ctl_start, 0);
  endtask

  task automatic t_invalid();
    int n; int s0 = n_starts;
    issue(4'hA, 20'h00010, 1, '0); wait_result(n);
    check_eq("R5", "code 1010", res_code, 4);
    check_eq("R12", "reject latency", n, 1);
    issue(4'h3, 20'h00010, 1, '0); wait_result(n);
    check_eq("R5", "code 0011", res_code, 4);
    check_eq("R5", "no start on invalid", n_starts - s0, 0);
    @(negedge clk);
    check_eq("R12", "single result pulse", res_valid, 0);
  endtask

  task automatic t_too_big();
    int n; int s0 = n_starts;
    issue(4'h8, 20'h00020, 17, '0); wait_result(n);
    check_eq("R3", "write len 17", res_code, 5);
    issue(4'h9, 20'h00020, 20, '0); wait_result(n);
    check_eq("R4", "read len 20", res_code, 5);
    check_eq("R3", "no start on oversize", n_starts - s0, 0);
    issue(4'h8, 20'h00020, 16, {16{8'h5C}});
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R3", "write len 16 tx len", tx_len_q, 20);
    check_eq("R11", "write len 16 count", res_count, 16);
    issue(4'h9, 20'h00020, 19, '0);
    serve(0, 0, 20, {{19{8'h77}}, 8'h00}); wait_result(n);
    check_eq("R4", "read len 19 ok", res_code, 0);
    check_eq("R10", "read len 19 count", res_count, 19);
    check_eq("R10", "read len 19 data", res_data == {19{8'h77}}, 1);
  endtask

  task automatic t_write();
    int n;
    issue(4'h8, 20'h5A1B2, 3, 128'h332211);
    check_eq("R12", "ready low while busy", req_ready, 0);
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R3", "write tx len", tx_len_q, 7);
    check_eq("R1", "write frame", tx_q == 160'h33221102B2A185, 1);
    check_eq("R11", "write full count", res_count, 3);
    check_eq("R12", "decode latency", n, 1);
    check_eq("R11", "write code", res_code, 0);
    issue(4'h0, 20'h00050, 3, 128'h0C0B0A);
    serve(0, 0, 2, 160'h0210); wait_result(n);
    check_eq("R11", "short write count", res_count, 2);
    check_eq("R10", "reply code", res_reply, 1);
    issue(4'h0, 20'h00050, 3, 128'h0C0B0A);
    serve(0, 0, 2, 160'h0900); wait_result(n);
    check_eq("R11", "short write clamp", res_count, 3);
    issue(4'h2, 20'h00050, 1, 128'hEE);
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R5", "status-update write tx len", tx_len_q, 5);
  endtask

  task automatic t_addr_only();
    int n;
    issue(4'h4, 20'h00050, 0, '0);
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R2", "write addr-only len", tx_len_q, 3);
    check_eq("R2", "write addr-only frame", tx_q == 160'h500040, 1);
    check_eq("R11", "addr-only count", res_count, 0);
    issue(4'h1, 20'hF0102, 0, '0);
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R2", "read addr-only len", tx_len_q, 3);
    check_eq("R1", "read addr-only frame", tx_q == 160'h02011F, 1);
    check_eq("R10", "read addr-only count", res_count, 0);
  endtask

  task automatic t_read();
    int n;
    issue(4'h9, 20'h00100, 4, '0);
    serve(0, 0, 5, 160'hDDCCBBAA00); wait_result(n);
    check_eq("R4", "read tx len", tx_len_q, 4);
    check_eq("R1", "read frame", tx_q == 160'h03000190, 1);
    check_eq("R10", "read count", res_count, 4);
    check_eq("R10", "read data", res_data == 152'hDDCCBBAA, 1);
    issue(4'h9, 20'h00100, 4, '0);
    serve(0, 0, 3, 160'h020120); wait_result(n);
    check_eq("R10", "short read count", res_count, 2);
    check_eq("R10", "short read reply", res_reply, 2);
    check_eq("R10", "short read data", res_data == 152'h0201, 1);
    issue(4'h9, 20'h00100, 4, '0);
    serve(0, 0, 8, 160'h0706050403020100); wait_result(n);
    check_eq("R10", "long reply clamp", res_count, 4);
    check_eq("R10", "long reply data", res_data == 152'h04030201, 1);
  endtask

  task automatic t_retry();
    int n, d1; int s0;
    issue(4'h8, 20'h00001, 1, 128'h01);
    serve(1, 0, 0, '0); d1 = d_cyc;
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R7", "timeout retry immediate", (s_cyc - d1) <= 1, 1);
    check_eq("R7", "ok after timeout", res_code, 0);
    issue(4'h8, 20'h00001, 1, 128'h01);
    serve(0, 1, 0, '0); d1 = d_cyc;
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R7", "backoff lower bound", (s_cyc - d1) >= B, 1);
    check_eq("R7", "backoff upper bound", (s_cyc - d1) <= B + 3, 1);
    s0 = n_starts;
    issue(4'h8, 20'h00001, 1, 128'h01);
    for (int i = 0; i < 5; i++) serve(1, 0, 0, '0);
    wait_result(n);
    check_eq("R8", "timeout exhaustion", res_code, 3);
    check_eq("R7", "five attempts", n_starts - s0, 5);
    check_eq("R12", "exhaustion latency", n, 0);
    s0 = n_starts;
    issue(4'h9, 20'h00001, 1, '0);
    for (int i = 0; i < 5; i++) serve(0, 1, 0, '0);
    wait_result(n);
    check_eq("R8", "receive-error exhaustion", res_code, 2);
    check_eq("R7", "five attempts rx err", n_starts - s0, 5);
    issue(4'h9, 20'h00001, 1, '0);
    for (int i = 0; i < 4; i++) serve(1, 0, 0, '0);
    serve(1, 1, 0, '0); wait_result(n);
    check_eq("R8", "both flags last", res_code, 2);
  endtask

  task automatic t_bad_size();
    int n;
    issue(4'h9, 20'h00002, 2, '0);
    serve(0, 0, 0, '0); wait_result(n);
    check_eq("R9", "reply size 0", res_code, 1);
    issue(4'h9, 20'h00002, 2, '0);
    serve(0, 0, 21, '0); wait_result(n);
    check_eq("R9", "reply size 21", res_code, 1);
  endtask

  task automatic t_busy();
    int n; int s0 = n_starts;
    ctl_busy = 1'b1;
    issue(4'h8, 20'h00003, 1, 128'h01); wait_result(n);
    check_eq("R6", "busy result", res_code, 1);
    check_eq("R6", "no start when busy", n_starts - s0, 0);
    check_eq("R6", "three polls spaced", n >= 2 * G, 1);
    issue(4'h8, 20'h00003, 1, 128'h01);
    repeat (G / 2) @(negedge clk);
    ctl_busy = 1'b0;
    serve(0, 0, 1, 160'h00); wait_result(n);
    check_eq("R6", "proceeds after busy clears", res_code, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_too_big();
    t_write();
    t_addr_only();
    t_read();
    t_retry();
    t_bad_size();
    t_busy();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule